// File: doc/BRIEF.md
# Conversion Result Register Pair with Atomic Read Lock

This block stores the latest 10-bit result from a successive-approximation converter and shows it to a processor as two byte-wide registers: a low byte and a high byte. A justification control decides how the result is spread across the two bytes. In right-justified form the value is packed toward bit 0. In left-justified form it is packed toward the top, so that software needing only 8 bits of precision can read the high byte alone.

Software that needs the whole result reads the low byte first and the high byte second. Reading the low byte freezes the stored result, so a conversion that finishes between the two reads cannot mix two samples. Reading the high byte lifts the freeze. A conversion that finishes while the freeze holds is thrown away. Its completion is still reported on the done output, so interrupt logic sees every conversion. The converter is outside this block: it is represented by a one-cycle valid strobe that carries the new result.

Top module: `adc_result_lock`

## Requirements
- R1: With `left_adj` low, `lo_byte` equals result bits 7:0. `hi_byte` bits 1:0 equal result bits 9:8, and `hi_byte` bits 7:2 are 0.
- R2: With `left_adj` high, `hi_byte` equals result bits 9:2. `lo_byte` bits 7:6 equal result bits 1:0, and `lo_byte` bits 5:0 are 0.
- R3: A change of `left_adj` re-presents the stored result on both byte outputs in the cycle after the edge that samples it, with no new conversion.
- R4: When the lock is open, a `res_valid` pulse stores `res_data`, and the new bytes are visible in the cycle after that edge.
- R5: A `rd_lo` strobe sets the lock. While the lock is held, `res_valid` pulses change neither byte. Their results are lost and do not appear after the lock is released.
- R6: A `rd_hi` strobe releases the lock, and the next conversion updates both bytes.
- R7: `done` is high for exactly the one cycle after each `res_valid` pulse, whether or not the result was stored.
- R8: A `rd_hi` strobe while no lock is held changes nothing: the bytes keep their values and the next conversion is stored normally.
- R9: A conversion in the same cycle as a `rd_lo` strobe (without `rd_hi`) is discarded. A conversion in the same cycle as the `rd_hi` strobe that releases a lock is stored.
- R10: Synchronous reset clears both bytes, the stored result, the lock and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe: a conversion has finished |
| res_data | input | 10 | Conversion result, sampled when `res_valid` is high |
| left_adj | input | 1 | 1 selects left justification, 0 selects right justification |
| rd_lo | input | 1 | One-cycle strobe: the processor reads the low byte |
| rd_hi | input | 1 | One-cycle strobe: the processor reads the high byte |
| lo_byte | output | 8 | Low result byte (registered) |
| hi_byte | output | 8 | High result byte (registered) |
| done | output | 1 | Registered completion pulse |

## Verification
The assertions assume that the read strobes and `res_valid` are single-cycle strobes sampled at the rising edge, and that `res_data` matters only in a cycle where `res_valid` is high. They also assume that a read in a given cycle sees the byte values registered before that edge. `left_adj` may change in any cycle. The directed stimulus changes every input on the falling clock edge and asserts each strobe for exactly one cycle. It places conversions before, during and in the same cycle as each kind of read, so that every lock transition is covered and no edge is driven ambiguously.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;

  // Read-lock state: open lets hardware write the result, held freezes it.
  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;

  // Priority of read strobes when both arrive together: the high-byte
  // read closes the pair, so the lock ends up open.
  function automatic lock_state_e next_lock(input lock_state_e cur,
                                            input logic rd_lo,
                                            input logic rd_hi);
    if (rd_hi)      return LK_OPEN;
    else if (rd_lo) return LK_HELD;
    else            return cur;
  endfunction

endpackage

// File: rtl/adc_lock_fsm.sv
module adc_lock_fsm
  import adc_res_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_lo,
  input  logic        rd_hi,
  output lock_state_e state_q,
  output lock_state_e state_nxt
);

  always_comb begin
    state_nxt = next_lock(state_q, rd_lo, rd_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_OPEN;
    else     state_q <= state_nxt;
  end

endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_data,
  output logic [RES_W-1:0] res_q,
  output logic [RES_W-1:0] res_nxt
);

  always_comb begin
    res_nxt = wr_en ? wr_data : res_q;
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_nxt;
  end

endmodule

// File: rtl/adc_res_justify.sv
module adc_res_justify #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RES_W-1:0]  res_in,
  input  logic              left_adj,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q
);

  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD    = PAIR_W - RES_W;

  logic [PAIR_W-1:0] right_w;
  logic [PAIR_W-1:0] left_w;
  logic [PAIR_W-1:0] pick_w;

  generate
    if (PAD == 0) begin : g_full
      assign right_w = res_in;
      assign left_w  = res_in;
    end else begin : g_pad
      assign right_w = {{PAD{1'b0}}, res_in};
      assign left_w  = {res_in, {PAD{1'b0}}};
    end
  endgenerate

  always_comb begin
    pick_w = left_adj ? left_w : right_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= pick_w[BYTE_W-1:0];
      hi_q <= pick_w[PAIR_W-1:BYTE_W];
    end
  end

endmodule

// File: rtl/adc_done_gen.sv
module adc_done_gen (
  input  logic clk,
  input  logic rst,
  input  logic res_valid,
  output logic done_q
);

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= res_valid;
  end

endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_adj,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte,
  output logic              done
);

  lock_state_e      lk_q;
  lock_state_e      lk_nxt;
  logic             upd_en;
  logic             lock_held;
  logic [RES_W-1:0] stored_res;
  logic [RES_W-1:0] res_nxt;

  adc_lock_fsm u_lock (
    .clk       (clk),
    .rst       (rst),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .state_q   (lk_q),
    .state_nxt (lk_nxt)
  );

  // A write is allowed only when the lock is open after this edge, so a
  // result landing with the low-byte read is dropped, and one landing with
  // the releasing high-byte read is kept.
  assign upd_en    = res_valid && (lk_nxt == LK_OPEN);
  assign lock_held = (lk_q == LK_HELD);

  adc_res_store #(.RES_W(RES_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (upd_en),
    .wr_data (res_data),
    .res_q   (stored_res),
    .res_nxt (res_nxt)
  );

  adc_res_justify #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_just (
    .clk      (clk),
    .rst      (rst),
    .res_in   (res_nxt),
    .left_adj (left_adj),
    .lo_q     (lo_byte),
    .hi_q     (hi_byte)
  );

  adc_done_gen u_done (
    .clk       (clk),
    .rst       (rst),
    .res_valid (res_valid),
    .done_q    (done)
  );

endmodule

// File: rtl/adc_result_lock_chk.sv
module adc_result_lock_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic              left_adj,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] lo_byte,
  input logic [BYTE_W-1:0] hi_byte,
  input logic              done,
  input logic              lock_held,
  input logic [RES_W-1:0]  stored_res
);

  localparam int PAD = 2 * BYTE_W - RES_W;
  localparam int HI_SHIFT = RES_W - BYTE_W;
  localparam logic [BYTE_W-1:0] LO_MASK = BYTE_W'((1 << PAD) - 1);

  // R1: right justification leaves the top of the high byte clear
  assert_right_pad_R1: assert property (@(posedge clk) disable iff (rst)
    !left_adj |=> ((hi_byte >> HI_SHIFT) == '0));

  // R2: left justification leaves the bottom of the low byte clear
  assert_left_pad_R2: assert property (@(posedge clk) disable iff (rst)
    left_adj |=> ((lo_byte & LO_MASK) == '0));

  // R4: an open-lock conversion is stored
  assert_store_open_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !lock_held && !rd_lo) |=> (stored_res == $past(res_data)));

  // R5: low-byte read sets the lock
  assert_lock_set_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> lock_held);

  // R5: the stored result is frozen while the lock is held
  assert_lock_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_held && !rd_hi) |=> $stable(stored_res));

  // R6: high-byte read releases the lock
  assert_lock_release_R6: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !lock_held);

  // R7: done follows each conversion by one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> done);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> !done);

  // R9: conversion together with the low-byte read is discarded
  assert_same_cycle_lo_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi && res_valid) |=> $stable(stored_res));

  // R10: reset clears outputs and lock
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (lo_byte == '0 && hi_byte == '0 && !lock_held && !done));

endmodule

bind adc_result_lock adc_result_lock_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .left_adj   (left_adj),
  .rd_lo      (rd_lo),
  .rd_hi      (rd_hi),
  .lo_byte    (lo_byte),
  .hi_byte    (hi_byte),
  .done       (done),
  .lock_held  (lock_held),
  .stored_res (stored_res)
);

// File: tb/adc_result_lock_test.sv
module adc_result_lock_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] lo_byte;
  logic [7:0] hi_byte;
  logic       done;

  int checks = 0;
  int errors = 0;
  logic [9:0] model_res = '0;

  always #4 clk = ~clk;

  adc_result_lock uut (
    .clk (clk), .rst (rst), .res_valid (res_valid), .res_data (res_data),
    .left_adj (left_adj), .rd_lo (rd_lo), .rd_hi (rd_hi),
    .lo_byte (lo_byte), .hi_byte (hi_byte), .done (done)
  );

  function automatic logic [7:0] exp_lo(input logic [9:0] r, input logic adj);
    return adj ? {r[1:0], 6'b0} : r[7:0];
  endfunction

  function automatic logic [7:0] exp_hi(input logic [9:0] r, input logic adj);
    return adj ? r[9:2] : {6'b0, r[9:8]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bytes(input string req);
    check(req, {hi_byte, lo_byte}, {exp_hi(model_res, left_adj), exp_lo(model_res, left_adj)});
  endtask

  // Drive one cycle at a falling edge, let the rising edge pass, then release.
  task automatic cyc(input logic v, input logic [9:0] d, input logic rl, input logic rh);
    res_valid = v; res_data = d; rd_lo = rl; rd_hi = rh;
    @(negedge clk);
    res_valid = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset bytes", {hi_byte, lo_byte}, 16'h0000);
    check("R10 reset done", {15'b0, done}, 16'h0000);
  endtask

  task automatic t_right();
    left_adj = 1'b0;
    cyc(1'b1, 10'h2A5, 1'b0, 1'b0); model_res = 10'h2A5;
    check("R1 R4 right layout", {hi_byte, lo_byte}, 16'h02A5);
    check("R7 done after conversion", {15'b0, done}, 16'h0001);
    cyc(1'b0, '0, 1'b0, 1'b0);
    check("R7 done one cycle", {15'b0, done}, 16'h0000);
  endtask

  task automatic t_left();
    left_adj = 1'b1;
    cyc(1'b0, '0, 1'b0, 1'b0);
    check("R2 R3 left layout no new conversion", {hi_byte, lo_byte}, 16'hA940);
    left_adj = 1'b0;
    cyc(1'b0, '0, 1'b0, 1'b0);
    check("R3 back to right", {hi_byte, lo_byte}, 16'h02A5);
  endtask

  task automatic t_lock();
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, 10'h155, 1'b0, 1'b0);
    check_bytes("R5 frozen while held");
    check("R7 done while held", {15'b0, done}, 16'h0001);
    cyc(1'b1, 10'h0AA, 1'b0, 1'b0);
    check_bytes("R5 still frozen");
    cyc(1'b0, '0, 1'b0, 1'b1);
    check_bytes("R5 lost result not shown");
    cyc(1'b1, 10'h0F0, 1'b0, 1'b0); model_res = 10'h0F0;
    check_bytes("R6 update after release");
  endtask

  task automatic t_hi_alone();
    cyc(1'b0, '0, 1'b0, 1'b1);
    check_bytes("R8 lone high read no change");
    cyc(1'b1, 10'h3C3, 1'b0, 1'b0); model_res = 10'h3C3;
    check_bytes("R8 next conversion stored");
  endtask

  task automatic t_same_cycle();
    cyc(1'b1, 10'h111, 1'b1, 1'b0);
    check_bytes("R9 conversion with low read dropped");
    check("R7 done for dropped", {15'b0, done}, 16'h0001);
    cyc(1'b1, 10'h222, 1'b0, 1'b1); model_res = 10'h222;
    check_bytes("R9 conversion with releasing high read kept");
  endtask

  task automatic t_bounds();
    for (int m = 0; m < 2; m++) begin
      left_adj = logic'(m);
      cyc(1'b1, 10'h3FF, 1'b0, 1'b0); model_res = 10'h3FF;
      check_bytes(m ? "R2 all ones left" : "R1 all ones right");
      cyc(1'b1, 10'h000, 1'b0, 1'b0); model_res = 10'h000;
      check_bytes(m ? "R2 zero left" : "R1 zero right");
    end
    left_adj = 1'b0;
  endtask

  task automatic t_reset_mid();
    cyc(1'b1, 10'h1EE, 1'b0, 1'b0); model_res = 10'h1EE;
    cyc(1'b0, '0, 1'b1, 1'b0);
    rst = 1'b1;
    cyc(1'b0, '0, 1'b0, 1'b0);
    rst = 1'b0; model_res = '0;
    check("R10 reset clears bytes", {hi_byte, lo_byte}, 16'h0000);
    cyc(1'b1, 10'h099, 1'b0, 1'b0); model_res = 10'h099;
    check_bytes("R10 reset clears lock");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_right();
    t_left();
    t_lock();
    t_hi_alone();
    t_same_cycle();
    t_bounds();
    t_reset_mid();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule